// File: doc/BRIEF.md
# Local Bus Wait-State Generator

This block sets the number of wait states in each data beat of a local bus access in which the bridge is the bus master. At the start of every data access a down counter is loaded with a configured wait count. Until that counter reaches zero the beat cannot complete, and the external ready and burst-terminate inputs are not looked at.

When the counter is at zero, the beat completes straight away if external ready is disabled. If external ready is enabled, an active-low ready input decides how many more wait states are added. An active-low burst-terminate input has priority over ready. When it is asserted with the counter at zero, the beat completes and a terminate flag tells the master to end the burst. The surrounding sequencer pulses a start strobe for each beat and waits for the completion strobe.

Top module: `lbus_wait_gen`

## Requirements
- R1: While and after reset, before any access starts, `beat_done`, `burst_term` and `wait_state` are low.
- R2: On a rising edge where `wait_state` is low and `beat_start` is high, the access starts and the counter loads `wait_cfg` (N). Changes to `wait_cfg` after that edge have no effect on the beat.
- R3: With `rdy_en` low, `ready_n` has no effect. `beat_done` is high for one cycle after rising edge N+1 counted from the start edge.
- R4: With `rdy_en` high, `ready_n` is ignored on edges 1..N. From edge N+1 on, each edge that samples `ready_n` high (1 = not ready) adds one wait state. `beat_done` follows the first such edge that samples `ready_n` low.
- R5: `bterm_n` is ignored on edges 1..N, while the counter is non-zero.
- R6: When `bterm_n` is sampled low (0 = terminate) on an edge at or after N+1, `beat_done` and `burst_term` are both high in the following cycle, whatever `ready_n` and `rdy_en` are.
- R7: `burst_term` is never high without `beat_done`. Both are single-cycle pulses.
- R8: The counter stays at zero while it waits on ready and does not wrap.
- R9: `beat_start` is ignored while an access is in progress.
- R10: `wait_state` is high from the cycle after the start edge until the edge on which the beat completes. It is low in the `beat_done` cycle, and a new access may start on that cycle's closing edge.
- R11: With N = 0, the beat can complete, or sample ready, on the first edge after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_start | input | 1 | Start of a data beat |
| wait_cfg | input | CNT_W | Configured wait count, captured at start |
| rdy_en | input | 1 | Enables the external ready input |
| ready_n | input | 1 | External ready, active low |
| bterm_n | input | 1 | Burst terminate, active low |
| beat_done | output | 1 | Data beat complete, one-cycle pulse |
| burst_term | output | 1 | Beat completed by terminate, end the burst |
| wait_state | output | 1 | Access in progress, wait state inserted |

## Verification
Every wait count of a 4-bit configuration is combined with both settings of `rdy_en`, zero to three ready-extension cycles, and terminate either absent or asserted at the completion edge. During the counting phase, `ready_n` is held asserted, which tells an ignore-until-zero design from one that completes early. A second noise pattern also asserts `bterm_n` and a repeated `beat_start`, which exposes early terminate sampling and mid-access restarts. `wait_cfg` is inverted after each start edge, which separates a captured count from a live one. Back-to-back accesses cover the restart on the completion cycle.

// File: rtl/lbw_pkg.sv
package lbw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } lbw_state_e;

  typedef struct packed {
    logic finish;
    logic term;
  } lbw_resolve_t;

endpackage

// File: rtl/lbw_down_counter.sv
module lbw_down_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;

  // saturating: decrement only requested when non-zero, guarded again here
  always_comb begin
    cnt_en = load | (dec & ~zero);
    cnt_d  = cnt;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && !zero) begin
      cnt_d = cnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/lbw_resolve.sv
module lbw_resolve
  import lbw_pkg::*;
(
  input  logic         rdy_en,
  input  logic         ready_n,
  input  logic         bterm_n,
  output lbw_resolve_t res
);

  // terminate outranks ready; ready only matters when enabled
  always_comb begin
    res.term   = 1'b0;
    res.finish = 1'b0;
    if (!bterm_n) begin
      res.term   = 1'b1;
      res.finish = 1'b1;
    end else if (!rdy_en) begin
      res.finish = 1'b1;
    end else if (!ready_n) begin
      res.finish = 1'b1;
    end
  end

endmodule

// File: rtl/lbw_fsm.sv
module lbw_fsm
  import lbw_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         beat_start,
  input  logic         cnt_zero,
  input  lbw_resolve_t res,
  output logic         cnt_load,
  output logic         cnt_dec,
  output logic         beat_done,
  output logic         burst_term,
  output logic         busy
);

  lbw_state_e state_q, state_d;
  logic       done_d, term_d;

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    term_d   = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (beat_start) begin
          cnt_load = 1'b1;
          state_d  = ST_COUNT;
        end
      end
      ST_COUNT, ST_HOLD: begin
        if (!cnt_zero) begin
          cnt_dec = 1'b1;
        end else if (res.finish) begin
          done_d  = 1'b1;
          term_d  = res.term;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_HOLD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      beat_done  <= 1'b0;
      burst_term <= 1'b0;
    end else begin
      state_q    <= state_d;
      beat_done  <= done_d;
      burst_term <= term_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/lbus_wait_gen.sv
module lbus_wait_gen
  import lbw_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_start,
  input  logic [CNT_W-1:0] wait_cfg,
  input  logic             rdy_en,
  input  logic             ready_n,
  input  logic             bterm_n,
  output logic             beat_done,
  output logic             burst_term,
  output logic             wait_state
);

  logic             cnt_load;
  logic             cnt_dec;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  lbw_resolve_t     res;

  lbw_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (wait_cfg),
    .dec      (cnt_dec),
    .cnt      (cnt_val),
    .zero     (cnt_zero)
  );

  lbw_resolve u_res (
    .rdy_en  (rdy_en),
    .ready_n (ready_n),
    .bterm_n (bterm_n),
    .res     (res)
  );

  lbw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_start (beat_start),
    .cnt_zero   (cnt_zero),
    .res        (res),
    .cnt_load   (cnt_load),
    .cnt_dec    (cnt_dec),
    .beat_done  (beat_done),
    .burst_term (burst_term),
    .busy       (wait_state)
  );

endmodule

// File: rtl/lbus_wait_gen_chk.sv
module lbus_wait_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic rdy_en,
  input logic ready_n,
  input logic bterm_n,
  input logic cnt_zero,
  input logic beat_done,
  input logic burst_term,
  input logic wait_state
);

  // R7
  term_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_term |-> beat_done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |=> !beat_done);

  // R3
  done_when_rdy_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_state && cnt_zero && !rdy_en) |=> beat_done);

  // R6
  term_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_state && cnt_zero && !bterm_n) |=> (beat_done && burst_term));

  // R5
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_state && !cnt_zero) |=> !beat_done);

  // R4
  hold_on_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_state && cnt_zero && rdy_en && ready_n && bterm_n) |=> (wait_state && !beat_done));

  // R8
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_state && cnt_zero) |=> cnt_zero);

endmodule

bind lbus_wait_gen lbus_wait_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rdy_en     (rdy_en),
  .ready_n    (ready_n),
  .bterm_n    (bterm_n),
  .cnt_zero   (cnt_zero),
  .beat_done  (beat_done),
  .burst_term (burst_term),
  .wait_state (wait_state)
);

// File: tb/lbus_wait_gen_tb.sv
module lbus_wait_gen_tb;

  localparam int CNT_W = 4;
  localparam int NMAX  = (1 << CNT_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             beat_start;
  logic [CNT_W-1:0] wait_cfg;
  logic             rdy_en;
  logic             ready_n;
  logic             bterm_n;
  logic             beat_done;
  logic             burst_term;
  logic             wait_state;

  int checks;
  int errors;
  bit finished;

  lbus_wait_gen #(.CNT_W(CNT_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_start (beat_start),
    .wait_cfg   (wait_cfg),
    .rdy_en     (rdy_en),
    .ready_n    (ready_n),
    .bterm_n    (bterm_n),
    .beat_done  (beat_done),
    .burst_term (burst_term),
    .wait_state (wait_state)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp, input int n, input int j);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s N=%0d edge=%0d actual=%b expected=%b", req, n, j, act, exp);
    end
  endtask

  // one access: N waits, ren ready enable, x extension, tm terminate, nz noise mode
  task automatic run_access(input int n, input bit ren, input int x, input bit tm, input bit nz);
    int  jz;
    int  jd;
    bit  texp;
    jz   = n + 1 + x;
    jd   = ren ? jz : (n + 1);
    texp = tm && (ren || x == 0);
    @(negedge clk);
    beat_start = 1'b1;
    wait_cfg   = CNT_W'(n);
    rdy_en     = ren;
    ready_n    = 1'b0;
    bterm_n    = 1'b1;
    @(posedge clk);
    #2;
    // R2: captured count must not follow later changes
    wait_cfg = ~CNT_W'(n);
    for (int j = 1; j <= jd; j++) begin
      @(negedge clk);
      if (j <= n) begin
        // R5 R9: counting phase noise
        ready_n    = 1'b0;
        bterm_n    = nz ? 1'b0 : 1'b1;
        beat_start = nz;
      end else begin
        beat_start = 1'b0;
        ready_n    = (ren && j == jz) ? 1'b0 : 1'b1;
        bterm_n    = (tm && j == jz) ? 1'b0 : 1'b1;
      end
      @(posedge clk);
      #2;
      if (ren) chk("R4 beat_done", beat_done, j == jd, n, j);
      else     chk("R3 beat_done", beat_done, j == jd, n, j);
      chk("R6 burst_term", burst_term, (j == jd) && texp, n, j);
      chk("R10 wait_state", wait_state, j < jd, n, j);
    end
    beat_start = 1'b0;
    ready_n    = 1'b1;
    bterm_n    = 1'b1;
  endtask

  initial begin
    checks     = 0;
    errors     = 0;
    finished   = 0;
    rst_n      = 1'b0;
    beat_start = 1'b0;
    wait_cfg   = '0;
    rdy_en     = 1'b0;
    ready_n    = 1'b1;
    bterm_n    = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 beat_done", beat_done, 1'b0, 0, 0);
    chk("R1 burst_term", burst_term, 1'b0, 0, 0);
    chk("R1 wait_state", wait_state, 1'b0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    chk("R1 idle beat_done", beat_done, 1'b0, 0, 0);
    chk("R1 idle wait_state", wait_state, 1'b0, 0, 0);

    // R8 R11: full sweep including N=0 and long ready extensions
    for (int n = 0; n <= NMAX; n++)
      for (int ren = 0; ren < 2; ren++)
        for (int x = 0; x < 4; x++)
          for (int tm = 0; tm < 2; tm++)
            for (int nz = 0; nz < 2; nz++)
              run_access(n, ren[0], x, tm[0], nz[0]);

    @(negedge clk);
    @(posedge clk);
    #2;
    chk("R7 idle after sweep", beat_done | burst_term | wait_state, 1'b0, 0, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule